// File: doc/BRIEF.md
# Serial Register Slave for a Two-Channel Blink Controller

This block is a two-wire serial bus slave that sits in front of a small blink controller. It oversamples the clock and data lines with a fast system clock, recognises its own bus address, and gives the master access to a six-entry file of 8-bit locations. Five of these locations are configuration registers: two blink period prescalers, two duty values and a selector for the LED outputs. They are exported as parallel buses to the blink logic. The remaining location is read-only and shows the live level of the two LED pins.

Every write transaction starts with a command byte. That byte sets a 3-bit register pointer and a flag that makes the pointer advance after each data byte. With the flag set, a master can program the whole configuration in one burst. It can then read the registers back by issuing a repeated START without sending the pointer again. The data line is open-drain, so the block only produces an output enable, which pulls the line low while it is asserted.

Top module: `blink_cfg_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1,1,0,0,0,0 followed by the level of `addr_sel_i`. Bit 0 of the address byte selects a read (1) or a write (0). Any other address is not acknowledged, so SDA stays high in the acknowledge slot.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START in any state, including partway through a transfer, returns the block to address reception.
- R3: The first byte after an acknowledged write address is the command byte. Bit 4 is the auto-advance flag and bits 2:0 are the pointer. The command value is 00h after reset.
- R4: A data byte is stored in the register the pointer names: 1 is prescaler 0, 2 is duty 0, 3 is prescaler 1, 4 is duty 1 and 5 is the LED selector. Each register appears on its own output bus.
- R5: When the flag is set, the pointer advances by one after every data byte written or read, and it wraps from 5 to 0. When the flag is clear, the pointer does not move.
- R6: Location 0 reads as {6'b0, led_pin_i[1:0]}. A data byte written to location 0 is acknowledged, changes no register, and still advances the pointer.
- R7: After reset, both prescalers are FFh, both duty registers are 80h, the LED selector is 55h (every 2-bit field 01) and SDA is released.
- R8: The block acknowledges every byte it receives. During a read it keeps sending bytes while the master acknowledges, and it releases SDA after a master NACK. The SDA enable changes only while SCL is low.
- R9: While `rst_ni` is low, all registers hold their reset values, whatever the bus is doing.
- R10: The pointer keeps its value across STOP and repeated START, so a read that follows a pointer write begins at that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| addr_sel_i | input | 1 | Selects the low address bit |
| led_pin_i | input | 2 | Live levels of the two LED pins |
| psc0_o | output | 8 | Prescaler for blink channel 0 |
| duty0_o | output | 8 | Duty value for blink channel 0 |
| psc1_o | output | 8 | Prescaler for blink channel 1 |
| duty1_o | output | 8 | Duty value for blink channel 1 |
| led_sel_o | output | 8 | LED source selector, 2 bits per pin |

## Verification
The hardest case to reach is the hand-off of the data line in the middle of a transaction. After a pointer write, a repeated START turns the block from receiver into transmitter. Then, at the end of a read burst, the pointer wraps from the selector register into the read-only input location. The bench drives a bit-level master that writes command byte 15h and, without a STOP, re-addresses for a read. It acknowledges the selector byte and NACKs the following pin byte. It then opens a new transaction without any pointer write, which shows that the wrapped pointer was kept.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int REG_W    = 8;
  localparam int PTR_W    = 3;
  localparam int N_LOC    = 6;
  localparam int CFG_CNT  = N_LOC - 1;
  localparam int LAST_PTR = N_LOC - 1;
  localparam int CNT_W    = 4;
  localparam logic [5:0] ADDR_PREFIX = 6'b110000;
  localparam int AI_BIT   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_MACK
  } bus_st_e;

  function automatic logic [REG_W-1:0] cfg_reset(int idx);
    case (idx)
      1, 3:    return 8'hFF;
      2, 4:    return 8'h80;
      5:       return 8'h55;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcs_line_sync.sv
module bcs_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int STAGES = 2;
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1; sda_q <= '1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign sda_s_o    = sda_q[STAGES-1];
  assign scl_rise_o = scl_q[STAGES-1] & ~scl_d;
  assign scl_fall_o = ~scl_q[STAGES-1] & scl_d;
  assign start_o    = scl_q[STAGES-1] & scl_d & sda_d & ~sda_q[STAGES-1];
  assign stop_o     = scl_q[STAGES-1] & scl_d & ~sda_d & sda_q[STAGES-1];
endmodule

// File: rtl/bcs_bus_fsm.sv
module bcs_bus_fsm
  import bcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             addr_sel_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             sda_oe_o,
  output logic             cmd_we_o,
  output logic             data_we_o,
  output logic             rd_adv_o,
  output logic [REG_W-1:0] wdata_o
);
  bus_st_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] sh_q;
  logic             rw_q, first_q, nack_q;

  assign wdata_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0;
      rw_q <= 1'b0; first_q <= 1'b0; nack_q <= 1'b1;
      sda_oe_o <= 1'b0; cmd_we_o <= 1'b0; data_we_o <= 1'b0; rd_adv_o <= 1'b0;
    end else begin
      cmd_we_o <= 1'b0; data_we_o <= 1'b0; rd_adv_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR; cnt_q <= '0; sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE; sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise_i && cnt_q < CNT_W'(REG_W)) begin
              sh_q  <= {sh_q[REG_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_W'(REG_W)) begin
              if (state_q == ST_ADDR) begin
                if (sh_q[REG_W-1:1] == {ADDR_PREFIX, addr_sel_i}) begin
                  rw_q <= sh_q[0]; first_q <= 1'b1;
                  sda_oe_o <= 1'b1; state_q <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                cmd_we_o  <= first_q;
                data_we_o <= ~first_q;
                first_q   <= 1'b0;
                sda_oe_o  <= 1'b1; state_q <= ST_ACK;
              end
            end
          end
          ST_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              sh_q <= rd_data_i; sda_oe_o <= ~rd_data_i[REG_W-1]; state_q <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0; state_q <= ST_RX;
            end
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == CNT_W'(REG_W-1)) begin
              sda_oe_o <= 1'b0; rd_adv_o <= 1'b1; state_q <= ST_MACK;
            end else begin
              sh_q <= {sh_q[REG_W-2:0], 1'b0};
              sda_oe_o <= ~sh_q[REG_W-2];
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_MACK: begin
            if (scl_rise_i) nack_q <= sda_s_i;
            else if (scl_fall_i) begin
              if (!nack_q) begin
                sh_q <= rd_data_i; sda_oe_o <= ~rd_data_i[REG_W-1];
                cnt_q <= '0; state_q <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bcs_regfile.sv
module bcs_regfile
  import bcs_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cmd_we_i,
  input  logic                            data_we_i,
  input  logic                            rd_adv_i,
  input  logic [REG_W-1:0]                wdata_i,
  input  logic [1:0]                      pins_i,
  output logic [REG_W-1:0]                rd_data_o,
  output logic [PTR_W-1:0]                ptr_o,
  output logic                            ai_o,
  output logic [CFG_CNT-1:0][REG_W-1:0]   cfg_o
);
  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic             ai_q;

  assign ptr_nxt = (ptr_q >= PTR_W'(LAST_PTR)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0; ai_q <= 1'b0;
    end else if (cmd_we_i) begin
      ptr_q <= wdata_i[PTR_W-1:0]; ai_q <= wdata_i[AI_BIT];
    end else if ((data_we_i || rd_adv_i) && ai_q) begin
      ptr_q <= ptr_nxt;
    end
  end

  for (genvar g = 0; g < CFG_CNT; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cfg_o[g] <= cfg_reset(g + 1);
      else if (data_we_i && ptr_q == PTR_W'(g + 1)) cfg_o[g] <= wdata_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (ptr_q == '0) rd_data_o = {{(REG_W-2){1'b0}}, pins_i};
    for (int i = 0; i < CFG_CNT; i++)
      if (ptr_q == PTR_W'(i + 1)) rd_data_o = cfg_o[i];
  end

  assign ptr_o = ptr_q;
  assign ai_o  = ai_q;
endmodule

// File: rtl/blink_cfg_slave.sv
module blink_cfg_slave
  import bcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             addr_sel_i,
  input  logic [1:0]       led_pin_i,
  output logic [REG_W-1:0] psc0_o,
  output logic [REG_W-1:0] duty0_o,
  output logic [REG_W-1:0] psc1_o,
  output logic [REG_W-1:0] duty1_o,
  output logic [REG_W-1:0] led_sel_o
);
  logic sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic cmd_we_w, data_we_w, rd_adv_w, ai_w;
  logic [REG_W-1:0] wdata_w, rd_data_w;
  logic [PTR_W-1:0] ptr_w;
  logic [CFG_CNT-1:0][REG_W-1:0] cfg_w;

  bcs_line_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s_w), .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  bcs_bus_fsm u_fsm (
    .clk_i, .rst_ni, .sda_s_i(sda_s_w), .scl_rise_i(scl_rise_w),
    .scl_fall_i(scl_fall_w), .start_i(start_w), .stop_i(stop_w),
    .addr_sel_i, .rd_data_i(rd_data_w), .sda_oe_o,
    .cmd_we_o(cmd_we_w), .data_we_o(data_we_w), .rd_adv_o(rd_adv_w),
    .wdata_o(wdata_w)
  );

  bcs_regfile u_regs (
    .clk_i, .rst_ni, .cmd_we_i(cmd_we_w), .data_we_i(data_we_w),
    .rd_adv_i(rd_adv_w), .wdata_i(wdata_w), .pins_i(led_pin_i),
    .rd_data_o(rd_data_w), .ptr_o(ptr_w), .ai_o(ai_w), .cfg_o(cfg_w)
  );

  assign psc0_o    = cfg_w[0];
  assign duty0_o   = cfg_w[1];
  assign psc1_o    = cfg_w[2];
  assign duty1_o   = cfg_w[3];
  assign led_sel_o = cfg_w[4];
endmodule

// File: rtl/blink_cfg_slave_chk.sv
module blink_cfg_slave_chk
  import bcs_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             stop_i,
  input logic             data_we_i,
  input logic             rd_adv_i,
  input logic             ai_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic [REG_W-1:0] psc0_o,
  input logic [REG_W-1:0] duty0_o,
  input logic [REG_W-1:0] psc1_o,
  input logic [REG_W-1:0] duty1_o,
  input logic [REG_W-1:0] led_sel_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_i); // R8

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o); // R2

  AST_INPUT_LOC_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && ptr_i == '0) |=> ($stable(psc0_o) && $stable(duty0_o) &&
     $stable(psc1_o) && $stable(duty1_o) && $stable(led_sel_o))); // R6

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_we_i || rd_adv_i) && ai_i && ptr_i == PTR_W'(LAST_PTR)) |=> ptr_i == '0); // R5

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_we_i || rd_adv_i) && !ai_i) |=> $stable(ptr_i)); // R5

  AST_RESET_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (psc0_o == 8'hFF && duty0_o == 8'h80 && psc1_o == 8'hFF &&
     duty1_o == 8'h80 && led_sel_o == 8'h55 && !sda_oe_o)); // R7
endmodule

bind blink_cfg_slave blink_cfg_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .stop_i(stop_w), .data_we_i(data_we_w), .rd_adv_i(rd_adv_w), .ai_i(ai_w),
  .ptr_i(ptr_w), .psc0_o(psc0_o), .duty0_o(duty0_o), .psc1_o(psc1_o),
  .duty1_o(duty1_o), .led_sel_o(led_sel_o)
);

// File: tb/blink_cfg_slave_tb.sv
module blink_cfg_slave_tb;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0;
  logic addr_sel = 1'b0;
  logic [1:0] pins = 2'b11;
  logic sda_oe, sda_bus;
  logic [7:0] psc0, duty0, psc1, duty1, led_sel;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  byte unsigned exp_q[$];
  string        tag_q[$];
  byte unsigned obs_byte;
  event         obs_ev;

  always #2.5 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);

  blink_cfg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .led_pin_i(pins),
    .psc0_o(psc0), .duty0_o(duty0), .psc1_o(psc1), .duty1_o(duty1),
    .led_sel_o(led_sel)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qtr(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_low = 1'b0; qtr(); m_scl = 1'b1; qtr();
    m_low = 1'b1; qtr(); m_scl = 1'b0; qtr();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qtr(); m_scl = 1'b1; qtr(); m_low = 1'b0; qtr();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qtr(); m_scl = 1'b1; qtr(); qtr(); m_scl = 1'b0; qtr();
    end
    m_low = 1'b0; qtr(); m_scl = 1'b1; qtr(); ack = sda_bus; qtr(); m_scl = 1'b0; qtr();
  endtask

  task automatic wr(string req, input logic [7:0] b, input logic exp_ack);
    logic a;
    send_byte(b, a);
    chk(req, a, exp_ack);
  endtask

  task automatic rd(input logic nack, input logic [7:0] exp, string req);
    logic [7:0] d;
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qtr(); m_scl = 1'b1; qtr(); d[i] = sda_bus; qtr(); m_scl = 1'b0;
    end
    exp_q.push_back(exp); tag_q.push_back(req);
    obs_byte = d; ->obs_ev;
    m_low = ~nack; qtr(); m_scl = 1'b1; qtr(); qtr(); m_scl = 1'b0; qtr();
    m_low = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(obs_ev);
      #0;
      if (exp_q.size() == 0) chk("R8 unexpected read", obs_byte, 8'hxx);
      else begin
        automatic byte unsigned e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, obs_byte, e);
      end
    end
  end

  task automatic chk_cfg(string req, logic [7:0] a, b, c, d, e);
    chk({req, " psc0"}, psc0, a);
    chk({req, " duty0"}, duty0, b);
    chk({req, " psc1"}, psc1, c);
    chk({req, " duty1"}, duty1, d);
    chk({req, " led_sel"}, led_sel, e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    chk_cfg("R9 during reset", 8'hFF, 8'h80, 8'hFF, 8'h80, 8'h55);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_cfg("R7 reset", 8'hFF, 8'h80, 8'hFF, 8'h80, 8'h55);
    chk("R7 sda released", sda_oe, 1'b0);

    // R3: command is 00h after reset -> location 0, no advance
    bus_start(); wr("R1 read addr ack", 8'hC1, 1'b0);
    rd(1'b0, 8'h03, "R3 reset ptr reads input loc");
    rd(1'b1, 8'h03, "R3 reset flag clear no advance");
    bus_stop();

    // R1: wrong address is not acknowledged
    bus_start(); wr("R1 foreign addr nack", 8'hC2, 1'b1); bus_stop();

    // R4 R5: auto-advanced burst from pointer 1
    bus_start(); wr("R1 write addr ack", 8'hC0, 1'b0);
    wr("R8 cmd ack", 8'h11, 1'b0);
    wr("R8 data ack", 8'h2B, 1'b0); wr("R8 data ack", 8'h80, 1'b0);
    wr("R8 data ack", 8'h0A, 1'b0); wr("R8 data ack", 8'hC0, 1'b0);
    wr("R8 data ack", 8'h0E, 1'b0);
    bus_stop();
    chk_cfg("R4 burst", 8'h2B, 8'h80, 8'h0A, 8'hC0, 8'h0E);

    // R2 R10: repeated START read-back
    bus_start(); wr("R1", 8'hC0, 1'b0); wr("R8", 8'h11, 1'b0);
    bus_start(); wr("R2 repeated start addr ack", 8'hC1, 1'b0);
    rd(1'b0, 8'h2B, "R10 readback psc0");
    rd(1'b0, 8'h80, "R5 readback duty0");
    rd(1'b0, 8'h0A, "R5 readback psc1");
    rd(1'b0, 8'hC0, "R5 readback duty1");
    rd(1'b1, 8'h0E, "R5 readback led_sel");
    repeat (10) @(negedge clk);
    chk("R8 release after nack", sda_oe, 1'b0);
    bus_stop();

    // R5 R6: wrap from 5 into input location
    pins = 2'b10;
    bus_start(); wr("R1", 8'hC0, 1'b0); wr("R8", 8'h15, 1'b0);
    bus_start(); wr("R2", 8'hC1, 1'b0);
    rd(1'b0, 8'h0E, "R5 led_sel before wrap");
    rd(1'b1, 8'h02, "R6 pins after wrap");
    bus_stop();

    // R10: pointer kept across transactions (now 1)
    bus_start(); wr("R1", 8'hC1, 1'b0);
    rd(1'b1, 8'h2B, "R10 pointer kept");
    bus_stop();

    // R6: write to input location ignored but advances
    bus_start(); wr("R1", 8'hC0, 1'b0); wr("R8", 8'h10, 1'b0);
    wr("R6 input write acked", 8'h77, 1'b0);
    wr("R8", 8'h33, 1'b0);
    bus_stop();
    chk_cfg("R6 input write ignored", 8'h33, 8'h80, 8'h0A, 8'hC0, 8'h0E);

    // R5: flag clear -> pointer stays on duty0
    bus_start(); wr("R1", 8'hC0, 1'b0); wr("R8", 8'h02, 1'b0);
    wr("R8", 8'h40, 1'b0); wr("R8", 8'h41, 1'b0);
    bus_stop();
    chk_cfg("R5 no advance write", 8'h33, 8'h41, 8'h0A, 8'hC0, 8'h0E);
    bus_start(); wr("R1", 8'hC0, 1'b0); wr("R8", 8'h02, 1'b0);
    bus_start(); wr("R2", 8'hC1, 1'b0);
    rd(1'b0, 8'h41, "R5 no advance read 1");
    rd(1'b1, 8'h41, "R5 no advance read 2");
    bus_stop();

    // R1: select pin changes the address
    addr_sel = 1'b1;
    bus_start(); wr("R1 sel=1 old addr nack", 8'hC0, 1'b1); bus_stop();
    bus_start(); wr("R1 sel=1 new addr ack", 8'hC2, 1'b0);
    wr("R8", 8'h05, 1'b0); wr("R4 led_sel via sel=1", 8'hA5, 1'b0);
    bus_stop();
    chk("R4 led_sel", led_sel, 8'hA5);
    addr_sel = 1'b0;

    // R2: START mid-byte aborts the partial byte
    bus_start(); wr("R1", 8'hC0, 1'b0); wr("R8", 8'h03, 1'b0);
    m_low = 1'b0; qtr(); m_scl = 1'b1; qtr(); qtr(); m_scl = 1'b0; qtr();
    bus_start(); wr("R2 addr after abort", 8'hC1, 1'b0);
    rd(1'b1, 8'h0A, "R2 aborted byte not stored");
    bus_stop();

    // R9: reset in the middle of a write
    bus_start(); wr("R1", 8'hC0, 1'b0); wr("R8", 8'h01, 1'b0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_cfg("R9 held in reset", 8'hFF, 8'h80, 8'hFF, 8'h80, 8'h55);
    wr("R9 bus ignored in reset", 8'h12, 1'b1);
    chk("R9 psc0 unchanged", psc0, 8'hFF);
    bus_stop();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_cfg("R7 after second reset", 8'hFF, 8'h80, 8'hFF, 8'h80, 8'h55);

    repeat (10) @(negedge clk);
    chk("R8 all reads consumed", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule